// File: doc/BRIEF.md
# Serially Configured Four-Input Logic Cell

This block is one programmable logic element for a small fabric of such cells. Its function comes from a look-up table that holds the complete truth table of its four logic inputs, so any Boolean function of those inputs can be set up. The table output can reach the cell output directly, or it can pass through a flip-flop on the user clock first. A mode bit held in configuration storage selects between the two paths.

Both the truth table and the mode bit are volatile. They sit in a shift register that is filled one bit per enabled clock. The last stage of that register drives a serial output, so the chains of several cells can be joined into one long chain and loaded from a single stream. After reset the storage is cleared and the cell output is held at a known low level. The chain can be reloaded at any time without a reset, and the new frame replaces the function the cell implements. While a load is in progress the user flip-flop keeps its value and the cell output is held low.

Top module: `lut_logic_cell`

## Requirements
- R1: While reset is asserted and after it is released, the chain holds all zeros: the cell output is 0, the serial output is 0, and the cell is in combinational mode with an all-zero table.
- R2: On each rising clock edge with `cfg_en` high, the chain shifts by one position and takes `cfg_sin` into its lowest stage. After 17 shifts, chain bit 16 is the mode bit (0 = combinational, 1 = registered) and bits 15:0 are the truth table. The first bit shifted in ends up in bit 16, and the last one ends up in bit 0.
- R3: The table entry that is selected has the index {lut_in[3], lut_in[2], lut_in[1], lut_in[0]}, read as an unsigned number with lut_in[0] as the least significant bit. In combinational mode `cell_out` equals that entry with no clock delay.
- R4: Any 4-input function can be loaded. Four-way XOR, four-way AND and majority (at least three inputs high) each match the expected output on all 16 input combinations.
- R5: In registered mode, `cell_out` equals the table entry selected at the most recent rising edge where `cfg_en` was low. A change of input between edges does not reach the output.
- R6: `cfg_sout` always shows chain bit 16. After k shifts (k < 17), it shows the bit that was in position 16−k before the load began, so a following cell receives the frame it displaces.
- R7: While `cfg_en` is high, `cell_out` is 0 and the user flip-flop holds its value. After `cfg_en` falls, a registered-mode cell shows that held value until the next edge.
- R8: A new frame can be loaded without a reset, and the cell then implements the new function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock; also times configuration shifts |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out, for the next cell |
| lut_in | input | 4 | Logic inputs that select the table entry |
| cell_out | output | 1 | Cell output, combinational or registered |

## Verification
The case that is hardest to reach from the ports is a flip-flop value that must survive a full reload. A captured 1 must stay in the register through seventeen shift cycles, even though the table behind it is being rewritten, and it must show up only in the gap between the end of the load and the next edge. The stimulus loads AND in registered mode and clocks in an all-ones input vector. It then loads XOR in registered mode, samples the output just after the enable falls, and expects the old 1. The serial-out cascade is checked in the same way: a second frame is shifted in behind a known first frame, and each displaced bit is compared as it leaves the chain.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
   typedef enum logic {
      MODE_COMB = 1'b0,
      MODE_REG  = 1'b1
   } out_mode_e;

   // table entries plus one mode bit
   function automatic int unsigned chain_len(input int unsigned n_in);
      return (32'd1 << n_in) + 32'd1;
   endfunction
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
   parameter int unsigned LEN = 17
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_en,
   input  logic           sin,
   output logic [LEN-1:0] chain_q,
   output logic           sout
);
   if (LEN < 2) begin : g_bad_len
      $error("lc_cfg_chain: LEN must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         chain_q <= '0;
      else if (shift_en)
         chain_q <= {chain_q[LEN-2:0], sin};
   end

   assign sout = chain_q[LEN-1];

   p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> chain_q[0] == $past(sin));

   p_chain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/lc_lut_mux.sv
module lc_lut_mux #(
   parameter int unsigned N_IN     = 4,
   parameter bit          MUX_TREE = 1'b1
) (
   input  logic [(1<<N_IN)-1:0] tbl,
   input  logic [N_IN-1:0]      sel,
   output logic                 y
);
   if (MUX_TREE) begin : g_tree
      // one 2:1 stage per input bit, lowest input closest to the table
      for (genvar l = 0; l <= N_IN; l++) begin : g_lvl
         logic [(1<<(N_IN-l))-1:0] v;
         if (l == 0) begin : g_leaf
            assign v = tbl;
         end else begin : g_stage
            for (genvar j = 0; j < (1 << (N_IN - l)); j++) begin : g_n
               assign v[j] = sel[l-1] ? g_lvl[l-1].v[2*j+1] : g_lvl[l-1].v[2*j];
            end
         end
      end
      assign y = g_lvl[N_IN].v[0];
   end else begin : g_index
      assign y = tbl[sel];
   end
endmodule

// File: rtl/lc_user_reg.sv
module lc_user_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 1'b0;
      else if (!hold)
         q <= d;
   end

   p_ff_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q));
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell #(
   parameter int unsigned N_IN     = 4,
   parameter bit          MUX_TREE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_en,
   input  logic            cfg_sin,
   output logic            cfg_sout,
   input  logic [N_IN-1:0] lut_in,
   output logic            cell_out
);
   import lutcell_pkg::*;

   localparam int unsigned TBL_W   = 1 << N_IN;
   localparam int unsigned CFG_W   = chain_len(N_IN);
   localparam int unsigned MODE_IX = CFG_W - 1;

   if (N_IN < 1 || N_IN > 6) begin : g_bad_n_in
      $error("lut_logic_cell: N_IN must be between 1 and 6");
   end

   logic [CFG_W-1:0] cfg_q;
   logic             lut_y;
   logic             ff_q;
   out_mode_e        mode;

   lc_cfg_chain #(.LEN(CFG_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_en),
      .sin      (cfg_sin),
      .chain_q  (cfg_q),
      .sout     (cfg_sout)
   );

   lc_lut_mux #(.N_IN(N_IN), .MUX_TREE(MUX_TREE)) u_lut (
      .tbl (cfg_q[TBL_W-1:0]),
      .sel (lut_in),
      .y   (lut_y)
   );

   lc_user_reg u_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (cfg_en),
      .d     (lut_y),
      .q     (ff_q)
   );

   assign mode = out_mode_e'(cfg_q[MODE_IX]);

   always_comb begin
      if (cfg_en)
         cell_out = 1'b0;
      else if (mode == MODE_REG)
         cell_out = ff_q;
      else
         cell_out = lut_y;
   end

   p_reg_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && mode == MODE_REG) |=> (cfg_en || cell_out == $past(lut_y)));

   p_sout_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> $stable(cfg_sout));
endmodule

// File: tb/tb_lut_logic_cell.sv
module tb_lut_logic_cell;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0;
   logic       cfg_sin = 1'b0;
   logic       cfg_sout;
   logic [3:0] lut_in = 4'd0;
   logic       cell_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic  exp_out;
      bit    chk_sout;
      logic  exp_sout;
      string tag;
   } item_t;
   item_t sb[$];

   lut_logic_cell dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
      .cfg_sout(cfg_sout), .lut_in(lut_in), .cell_out(cell_out)
   );

   always #10 clk = ~clk;

   task automatic check(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: one queued item is checked just after each rising edge
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            check({it.tag, " out"}, cell_out, it.exp_out);
            if (it.chk_sout) check({it.tag, " sout"}, cfg_sout, it.exp_sout);
         end
      end
   end

   function automatic logic [15:0] tt_xor();
      logic [15:0] t;
      for (int v = 0; v < 16; v++) t[v] = ^v[3:0];
      return t;
   endfunction
   function automatic logic [15:0] tt_and();
      logic [15:0] t;
      for (int v = 0; v < 16; v++) t[v] = &v[3:0];
      return t;
   endfunction
   function automatic logic [15:0] tt_maj();
      logic [15:0] t;
      for (int v = 0; v < 16; v++) t[v] = ($countones(v[3:0]) >= 3);
      return t;
   endfunction

   // frame = {mode, table}; bit 16 is shifted in first (R2)
   task automatic load(input logic [16:0] frame, input bit chk_old, input logic [16:0] old);
      item_t it;
      if (chk_old) begin
         @(negedge clk); #2;
         check("R6 sout before load", cfg_sout, old[16]);
      end
      for (int k = 0; k < 17; k++) begin
         @(negedge clk);
         cfg_en  = 1'b1;
         cfg_sin = frame[16-k];
         it.exp_out  = 1'b0;
         it.chk_sout = chk_old && (k < 16);
         it.exp_sout = (k < 16) ? old[15-k] : 1'b0;
         it.tag      = "R7 forced low / R6 cascade";
         sb.push_back(it);
      end
      @(negedge clk);
      cfg_en  = 1'b0;
      cfg_sin = 1'b0;
   endtask

   task automatic sweep(input logic [15:0] tt, input string tag);
      item_t it;
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         lut_in = v[3:0];
         it.exp_out  = tt[v];
         it.chk_sout = 1'b0;
         it.exp_sout = 1'b0;
         it.tag      = tag;
         sb.push_back(it);
      end
      @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [16:0] f_xor_c, f_and_r, f_maj_c, f_maj_r, f_xor_r;
      f_xor_c = {1'b0, tt_xor()};
      f_and_r = {1'b1, tt_and()};
      f_maj_c = {1'b0, tt_maj()};
      f_maj_r = {1'b1, tt_maj()};
      f_xor_r = {1'b1, tt_xor()};

      // R1: reset state
      lut_in = 4'd5;
      repeat (3) @(posedge clk);
      #2;
      check("R1 out in reset", cell_out, 1'b0);
      check("R1 sout in reset", cfg_sout, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      check("R1 out after reset", cell_out, 1'b0);
      lut_in = 4'd15;
      #1;
      check("R1 empty table in=15", cell_out, 1'b0);

      // R2 R3 R4: XOR combinational
      load(f_xor_c, 1'b1, 17'd0);
      sweep(tt_xor(), "R3/R4 xor comb");
      // R3 comb: output follows input without an edge
      lut_in = 4'd1; #1;
      check("R3 comb no delay in=1", cell_out, 1'b1);
      lut_in = 4'd3; #1;
      check("R3 comb no delay in=3", cell_out, 1'b0);

      // R8 R6: reload without reset, old frame shifted out
      load(f_maj_c, 1'b1, f_xor_c);
      sweep(tt_maj(), "R8/R4 maj comb");

      // R5: AND in registered mode
      load(f_and_r, 1'b1, f_maj_c);
      sweep(tt_and(), "R5/R4 and reg");
      // R5: input change between edges does not pass
      lut_in = 4'd15;
      @(posedge clk); #2;
      check("R5 captured 1", cell_out, 1'b1);
      @(negedge clk);
      lut_in = 4'd0; #1;
      check("R5 held between edges", cell_out, 1'b1);
      @(posedge clk); #2;
      check("R5 updates at edge", cell_out, 1'b0);

      // R7: captured 1 survives a full reload
      @(negedge clk);
      lut_in = 4'd15;
      @(posedge clk); #2;
      check("R7 pre-load capture", cell_out, 1'b1);
      load(f_xor_r, 1'b1, f_and_r);
      #2;
      check("R7 held value after load", cell_out, 1'b1);
      @(posedge clk); #2;
      check("R7 new table at edge in=15", cell_out, 1'b0);
      @(negedge clk);
      sweep(tt_xor(), "R5/R4 xor reg");

      load(f_maj_r, 1'b1, f_xor_r);
      sweep(tt_maj(), "R8/R4 maj reg");

      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule